// File: doc/BRIEF.md
# Byte-Serial Integer-Add Instruction Decoder

This block decodes the integer-add family of a variable-length instruction encoding. Instruction bytes arrive one per clock over a valid/ready byte port. The block walks through optional prefixes, the opcode, a ModRM byte and an immediate of one, two or four bytes. When an instruction is complete, it presents one decoded record on a valid/ready output. A downstream pipeline consumes the record. Address generation, operand fetch and execution happen in that pipeline, not here.

The record gives the following:

- the operand form;
- the operand size;
- the destination and source register numbers, each with a flag that selects a legacy high-byte register;
- a flag for a memory operand;
- the immediate, already sign-extended to the operand size;
- an invalid-opcode flag.

The block treats every byte from 0x40 to 0x4F as an extension prefix, as in 64-bit mode. The input stalls while a record waits to be accepted. After each accepted record, decoding restarts with a clean prefix state.

Top module: `addop_decoder`

## Requirements
- R1: `in_ready` is low whenever `out_valid` is high. A presented record holds its fields until it is accepted with `out_ready`. In the cycle after acceptance, `out_valid` is low, `in_ready` is high, and the prefix state is clear.
- R2: Opcode 0x04 gives form ACC (code 3) with 8-bit size. Opcode 0x05 gives form ACC at the current operand size. Both forms have destination register 0, source 0, and no memory flag.
- R3: Size codes are 0=8, 1=16, 2=32 and 3=64 bits. Opcodes 0x00, 0x02, 0x04 and 0x80 are always 8-bit. For the other opcodes, an active extension prefix with bit 3 (W) set gives 64 bits. Otherwise byte 0x66 gives 16 bits, and with neither the size is 32 bits.
- R4: Bytes 0xF0 and 0x66 anywhere among the prefixes set lock and size-override. An extension prefix (0x40-0x4F) applies only if it is the last byte before the opcode. One followed by 0xF0 or 0x66 is discarded.
- R5: Immediates are little-endian, with the first byte least significant. Opcodes 0x04, 0x80 and 0x83 take one byte. Opcodes 0x05 and 0x81 take two bytes at 16-bit size and four bytes otherwise.
- R6: The immediate is sign-extended from its received width to the operand size. Bits above the operand size read as zero.
- R7: The form codes and operands are as follows, with reg = ModRM[5:3] and rm = ModRM[2:0]:
  - 0x00/0x01 give form MR (1): destination rm, source reg.
  - 0x02/0x03 give form RM (0): destination reg, source rm.
  - 0x80/0x81/0x83 give form MI (2): destination rm, source 0.

  The memory flag is set when ModRM[7:6] is not 3.
- R8: Bit 2 (R) of an active extension prefix becomes bit 3 of the reg-side register number. Bit 0 (B) becomes bit 3 of the rm-side register number.
- R9: Some 8-bit register operands select a high byte. This applies when no extension prefix is active and the field value is 4-7. The number then reads as field-4 (0-3) and its high-byte flag is set. With an extension prefix active, fields 4-7 are plain registers 4-7 and the flag stays clear.
- R10: Opcodes 0x80/0x81/0x83 with a nonzero ModRM reg field end decoding at the ModRM byte with the invalid flag set, and no immediate is taken. Any opcode outside the supported set ends decoding at once with the invalid flag set.
- R11: A lock prefix with a register destination (form ACC, or ModRM[7:6] = 3) sets the invalid flag. This happens after the full instruction, including its immediate, has been taken. Lock with a memory destination is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder accepts a byte |
| out_valid | output | 1 | Decoded record valid |
| out_ready | input | 1 | Consumer accepts the record |
| out_form | output | 2 | Operand form (0 RM, 1 MR, 2 MI, 3 ACC) |
| out_size | output | 2 | Operand size code |
| out_dst | output | 4 | Destination register number |
| out_dst_hi | output | 1 | Destination is a legacy high-byte register |
| out_src | output | 4 | Source register number |
| out_src_hi | output | 1 | Source is a legacy high-byte register |
| out_mem | output | 1 | The rm operand is memory |
| out_imm | output | 64 | Sign-extended immediate |
| out_invalid | output | 1 | Invalid-opcode indication |

## Verification
A stale prefix, immediate or byte-count register corrupts the next record, not the current one. A wrong state usually shows up one instruction later as a wrong size, a truncated immediate, or an extra byte that is read as an opcode. The bench therefore runs instructions back to back. It places an invalid group opcode and a discarded extension prefix just before well-formed instructions. Each record is compared as soon as it is accepted. Random backpressure on the output shows whether a held record drifts or a byte is taken during the stall.

// File: rtl/addop_pkg.sv
package addop_pkg;
  typedef enum logic [1:0] {FORM_RM = 2'd0, FORM_MR = 2'd1, FORM_MI = 2'd2, FORM_ACC = 2'd3} form_e;
  typedef enum logic [1:0] {SZ8 = 2'd0, SZ16 = 2'd1, SZ32 = 2'd2, SZ64 = 2'd3} size_e;
  localparam logic [7:0] LOCK_BYTE = 8'hF0;
  localparam logic [7:0] OSZ_BYTE  = 8'h66;
endpackage

// File: rtl/addop_opclass.sv
module addop_opclass
  import addop_pkg::*;
(
  input  logic [7:0] op,
  output logic       known,
  output logic       byte_op,
  output form_e      form,
  output logic       has_modrm,
  output logic       grp,
  output logic       has_imm,
  output logic       imm_one
);
  always_comb begin
    known = 1'b1; byte_op = 1'b0; form = FORM_RM; has_modrm = 1'b0;
    grp = 1'b0; has_imm = 1'b0; imm_one = 1'b0;
    case (op)
      8'h00: begin byte_op = 1'b1; form = FORM_MR; has_modrm = 1'b1; end
      8'h01: begin form = FORM_MR; has_modrm = 1'b1; end
      8'h02: begin byte_op = 1'b1; form = FORM_RM; has_modrm = 1'b1; end
      8'h03: begin form = FORM_RM; has_modrm = 1'b1; end
      8'h04: begin byte_op = 1'b1; form = FORM_ACC; has_imm = 1'b1; imm_one = 1'b1; end
      8'h05: begin form = FORM_ACC; has_imm = 1'b1; end
      8'h80: begin byte_op = 1'b1; form = FORM_MI; has_modrm = 1'b1; grp = 1'b1;
                   has_imm = 1'b1; imm_one = 1'b1; end
      8'h81: begin form = FORM_MI; has_modrm = 1'b1; grp = 1'b1; has_imm = 1'b1; end
      8'h83: begin form = FORM_MI; has_modrm = 1'b1; grp = 1'b1; has_imm = 1'b1;
                   imm_one = 1'b1; end
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/addop_sext.sv
module addop_sext
  import addop_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int OUT_W = 64
) (
  input  logic [IN_W-1:0]  raw,
  input  logic [1:0]       len_code,
  input  size_e            size,
  output logic [OUT_W-1:0] value
);
  logic [OUT_W-1:0] ext;
  logic [OUT_W-1:0] mask;

  always_comb begin
    case (len_code)
      2'd0:    ext = OUT_W'($signed(raw[7:0]));
      2'd1:    ext = OUT_W'($signed(raw[15:0]));
      default: ext = OUT_W'($signed(raw[IN_W-1:0]));
    endcase
    case (size)
      SZ8:     mask = OUT_W'(8'hFF);
      SZ16:    mask = OUT_W'(16'hFFFF);
      SZ32:    mask = OUT_W'(32'hFFFF_FFFF);
      default: mask = '1;
    endcase
    value = ext & mask;
  end
endmodule

// File: rtl/addop_regmap.sv
module addop_regmap #(
  parameter int REG_W = 4
) (
  input  logic [2:0]       field,
  input  logic             ext,
  input  logic             byte_op,
  input  logic             rex_seen,
  input  logic             is_mem,
  output logic [REG_W-1:0] num,
  output logic             hi
);
  always_comb begin
    hi  = byte_op & ~rex_seen & ~is_mem & field[2];
    num = hi ? REG_W'(field[1:0]) : REG_W'({ext, field});
  end
endmodule

// File: rtl/addop_decoder.sv
module addop_decoder
  import addop_pkg::*;
#(
  parameter int IMM_W  = 32,
  parameter int DATA_W = 64,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_form,
  output logic [1:0]        out_size,
  output logic [REG_W-1:0]  out_dst,
  output logic              out_dst_hi,
  output logic [REG_W-1:0]  out_src,
  output logic              out_src_hi,
  output logic              out_mem,
  output logic [DATA_W-1:0] out_imm,
  output logic              out_invalid
);
  localparam int IMM_BYTES = IMM_W / 8;
  localparam int CNT_W     = $clog2(IMM_BYTES + 1);
  localparam int NOPS      = 2;

  typedef enum logic [1:0] {S_PFX, S_MODRM, S_IMM, S_OUT} state_e;

  state_e           state_q, state_d;
  logic             lock_q, lock_d, osz_q, osz_d;
  logic             rex_q, rex_d, rexw_q, rexw_d, rexr_q, rexr_d, rexb_q, rexb_d;
  logic             inv_q, inv_d;
  logic [7:0]       op_q, op_d, modrm_q, modrm_d;
  logic [IMM_W-1:0] imm_q, imm_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, len;

  logic       take;
  logic [7:0] op_sel;
  logic       c_known, c_byte, c_modrm, c_grp, c_imm, c_one;
  form_e      c_form;
  size_e      size;
  logic [1:0] len_code, mod_sel;
  logic       lock_bad, mem;

  assign take   = in_valid & in_ready;
  assign op_sel = (state_q == S_PFX) ? in_byte : op_q;

  addop_opclass u_cls (
    .op(op_sel), .known(c_known), .byte_op(c_byte), .form(c_form),
    .has_modrm(c_modrm), .grp(c_grp), .has_imm(c_imm), .imm_one(c_one)
  );

  always_comb begin
    if (c_byte)       size = SZ8;
    else if (rexw_q)  size = SZ64;
    else if (osz_q)   size = SZ16;
    else              size = SZ32;
    len_code = c_one ? 2'd0 : ((size == SZ16) ? 2'd1 : 2'd2);
    len      = c_one ? CNT_W'(1) : ((size == SZ16) ? CNT_W'(2) : CNT_W'(IMM_BYTES));
    mod_sel  = (state_q == S_MODRM) ? in_byte[7:6] : modrm_q[7:6];
    lock_bad = lock_q & ((c_form == FORM_ACC) | (mod_sel == 2'b11));
    mem      = c_modrm & (modrm_q[7:6] != 2'b11);
  end

  // next-state process
  always_comb begin
    state_d = state_q; lock_d = lock_q; osz_d = osz_q; rex_d = rex_q;
    rexw_d = rexw_q; rexr_d = rexr_q; rexb_d = rexb_q; inv_d = inv_q;
    op_d = op_q; modrm_d = modrm_q; imm_d = imm_q; cnt_d = cnt_q;
    case (state_q)
      S_PFX: if (take) begin
        if (in_byte == LOCK_BYTE) begin
          lock_d = 1'b1; rex_d = 1'b0; rexw_d = 1'b0; rexr_d = 1'b0; rexb_d = 1'b0;
        end else if (in_byte == OSZ_BYTE) begin
          osz_d = 1'b1; rex_d = 1'b0; rexw_d = 1'b0; rexr_d = 1'b0; rexb_d = 1'b0;
        end else if (in_byte[7:4] == 4'h4) begin
          rex_d = 1'b1; rexw_d = in_byte[3]; rexr_d = in_byte[2]; rexb_d = in_byte[0];
        end else begin
          op_d  = in_byte;
          imm_d = '0;
          cnt_d = '0;
          if (!c_known) begin
            inv_d = 1'b1; state_d = S_OUT;
          end else if (c_modrm) begin
            state_d = S_MODRM;
          end else begin
            state_d = S_IMM;
          end
        end
      end
      S_MODRM: if (take) begin
        modrm_d = in_byte;
        if (c_grp && (in_byte[5:3] != 3'd0)) begin
          inv_d = 1'b1; state_d = S_OUT;
        end else if (c_imm) begin
          state_d = S_IMM;
        end else begin
          inv_d = lock_bad; state_d = S_OUT;
        end
      end
      S_IMM: if (take) begin
        imm_d[8*int'(cnt_q) +: 8] = in_byte;
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q + CNT_W'(1) == len) begin
          inv_d = lock_bad; state_d = S_OUT;
        end
      end
      default: if (out_ready) begin
        state_d = S_PFX; lock_d = 1'b0; osz_d = 1'b0; rex_d = 1'b0;
        rexw_d = 1'b0; rexr_d = 1'b0; rexb_d = 1'b0; inv_d = 1'b0;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_PFX; lock_q <= 1'b0; osz_q <= 1'b0; rex_q <= 1'b0;
      rexw_q <= 1'b0; rexr_q <= 1'b0; rexb_q <= 1'b0; inv_q <= 1'b0;
      op_q <= '0; modrm_q <= '0; imm_q <= '0; cnt_q <= '0;
    end else begin
      state_q <= state_d; lock_q <= lock_d; osz_q <= osz_d; rex_q <= rex_d;
      rexw_q <= rexw_d; rexr_q <= rexr_d; rexb_q <= rexb_d; inv_q <= inv_d;
      op_q <= op_d; modrm_q <= modrm_d; imm_q <= imm_d; cnt_q <= cnt_d;
    end
  end

  // operand 0 is the reg side, operand 1 the rm side
  logic [REG_W-1:0] opnum [NOPS];
  logic             ophi  [NOPS];
  genvar gi;
  generate
    for (gi = 0; gi < NOPS; gi++) begin : g_op
      addop_regmap #(.REG_W(REG_W)) u_map (
        .field   (gi == 0 ? modrm_q[5:3] : modrm_q[2:0]),
        .ext     (gi == 0 ? rexr_q : rexb_q),
        .byte_op (c_byte),
        .rex_seen(rex_q),
        .is_mem  (gi == 0 ? 1'b0 : mem),
        .num     (opnum[gi]),
        .hi      (ophi[gi])
      );
    end
  endgenerate

  addop_sext #(.IN_W(IMM_W), .OUT_W(DATA_W)) u_sext (
    .raw(imm_q), .len_code(len_code), .size(size), .value(out_imm)
  );

  always_comb begin
    in_ready    = (state_q != S_OUT);
    out_valid   = (state_q == S_OUT);
    out_form    = c_form;
    out_size    = size;
    out_mem     = mem;
    out_invalid = inv_q;
    case (c_form)
      FORM_RM: begin out_dst = opnum[0]; out_dst_hi = ophi[0];
                     out_src = opnum[1]; out_src_hi = ophi[1]; end
      FORM_MR: begin out_dst = opnum[1]; out_dst_hi = ophi[1];
                     out_src = opnum[0]; out_src_hi = ophi[0]; end
      FORM_MI: begin out_dst = opnum[1]; out_dst_hi = ophi[1];
                     out_src = '0; out_src_hi = 1'b0; end
      default: begin out_dst = '0; out_dst_hi = 1'b0;
                     out_src = '0; out_src_hi = 1'b0; end
    endcase
  end

  // R1
  hold_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_imm) && $stable(out_invalid)
                                && $stable(out_size) && $stable(out_dst));
  // R1
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);
  // R6
  imm8_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_invalid && out_size == 2'd0 |-> out_imm[DATA_W-1:8] == '0);
  // R2
  acc_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_form == 2'd3 |-> !out_mem && out_dst == '0);
  // R9
  hibyte_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_dst_hi || out_src_hi) |-> out_size == 2'd0);
endmodule

// File: tb/sim_addop_decoder.sv
module sim_addop_decoder;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [1:0]  form, size;
    logic [3:0]  dst, src;
    logic        dh, sh, mem, inv;
    logic [63:0] imm;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, out_valid, out_dst_hi, out_src_hi, out_mem, out_invalid;
  logic [1:0] out_form, out_size;
  logic [3:0] out_dst, out_src;
  logic [63:0] out_imm;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  addop_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_form(out_form), .out_size(out_size),
    .out_dst(out_dst), .out_dst_hi(out_dst_hi), .out_src(out_src), .out_src_hi(out_src_hi),
    .out_mem(out_mem), .out_imm(out_imm), .out_invalid(out_invalid)
  );

  task automatic expv(string tag, logic [1:0] form, logic [1:0] size, logic [3:0] dst,
                      logic dh, logic [3:0] src, logic sh, logic mem, logic [63:0] imm);
    exp_t e;
    e.tag = tag; e.form = form; e.size = size; e.dst = dst; e.dh = dh;
    e.src = src; e.sh = sh; e.mem = mem; e.imm = imm; e.inv = 1'b0;
    q.push_back(e);
  endtask

  task automatic expi(string tag);
    exp_t e;
    e.tag = tag; e.inv = 1'b1; e.form = '0; e.size = '0; e.dst = '0; e.src = '0;
    e.dh = 1'b0; e.sh = 1'b0; e.mem = 1'b0; e.imm = '0;
    q.push_back(e);
  endtask

  // called right after a falling edge; returns after the byte was taken
  task automatic snd(logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops the expected record when the design's record is accepted
  initial begin : monitor
    int cyc = 0;
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = ((cyc % 3) != 1);
      if (out_valid && out_ready) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R1: unexpected record act inv=%0b exp none", out_invalid);
        end else begin
          e = q.pop_front();
          if (e.inv) begin
            if (out_invalid !== 1'b1) begin
              errors++;
              $display("FAIL %s: invalid act=%0b exp=1", e.tag, out_invalid);
            end
          end else if (out_invalid !== 1'b0 || out_form !== e.form || out_size !== e.size ||
                       out_dst !== e.dst || out_dst_hi !== e.dh || out_src !== e.src ||
                       out_src_hi !== e.sh || out_mem !== e.mem || out_imm !== e.imm) begin
            errors++;
            $display("FAIL %s: act inv=%0b f=%0d s=%0d d=%0d/%0b r=%0d/%0b m=%0b i=%h exp inv=0 f=%0d s=%0d d=%0d/%0b r=%0d/%0b m=%0b i=%h",
                     e.tag, out_invalid, out_form, out_size, out_dst, out_dst_hi, out_src,
                     out_src_hi, out_mem, out_imm, e.form, e.size, e.dst, e.dh, e.src,
                     e.sh, e.mem, e.imm);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=timeout exp=completion");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: reset act valid=%0b ready=%0b exp valid=0 ready=1", out_valid, in_ready);
    end
    // R2 accumulator, 8-bit
    expv("R2", 2'd3, 2'd0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 64'h7F);
    snd(8'h04); snd(8'h7F);
    expv("R6", 2'd3, 2'd0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 64'h80);
    snd(8'h04); snd(8'h80);
    // R5 four-byte little-endian
    expv("R5", 2'd3, 2'd2, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 64'h12345678);
    snd(8'h05); snd(8'h78); snd(8'h56); snd(8'h34); snd(8'h12);
    // R3 size override to 16
    expv("R3", 2'd3, 2'd1, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 64'hFFFE);
    snd(8'h66); snd(8'h05); snd(8'hFE); snd(8'hFF);
    // R6 32-bit immediate extended to 64
    expv("R6", 2'd3, 2'd3, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 64'hFFFFFFFF80000000);
    snd(8'h48); snd(8'h05); snd(8'h00); snd(8'h00); snd(8'h00); snd(8'h80);
    // R6 one-byte immediate extended to 32, 16, 64
    expv("R6", 2'd2, 2'd2, 4'd1, 1'b0, 4'd0, 1'b0, 1'b0, 64'hFFFFFFFF);
    snd(8'h83); snd(8'hC1); snd(8'hFF);
    expv("R6", 2'd2, 2'd1, 4'd1, 1'b0, 4'd0, 1'b0, 1'b0, 64'hFF80);
    snd(8'h66); snd(8'h83); snd(8'hC1); snd(8'h80);
    expv("R6", 2'd2, 2'd3, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFF);
    snd(8'h48); snd(8'h83); snd(8'hC0); snd(8'hFF);
    // R9 high byte without extension prefix, plain with it
    expv("R9", 2'd2, 2'd0, 4'd0, 1'b1, 4'd0, 1'b0, 1'b0, 64'h05);
    snd(8'h80); snd(8'hC4); snd(8'h05);
    expv("R9", 2'd2, 2'd0, 4'd4, 1'b0, 4'd0, 1'b0, 1'b0, 64'h05);
    snd(8'h40); snd(8'h80); snd(8'hC4); snd(8'h05);
    expv("R9", 2'd1, 2'd0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0, 64'h0);
    snd(8'h00); snd(8'hE0);
    // R8 reg extension
    expv("R8", 2'd1, 2'd0, 4'd0, 1'b0, 4'd12, 1'b0, 1'b0, 64'h0);
    snd(8'h44); snd(8'h00); snd(8'hE0);
    // R7 RM form with memory
    expv("R7", 2'd0, 2'd2, 4'd3, 1'b0, 4'd0, 1'b0, 1'b1, 64'h0);
    snd(8'h03); snd(8'h18);
    // R8 rm extension
    expv("R8", 2'd1, 2'd2, 4'd8, 1'b0, 4'd3, 1'b0, 1'b0, 64'h0);
    snd(8'h41); snd(8'h01); snd(8'hD8);
    // R10 group opcode with reg 1, then an unknown opcode, then a valid one
    expi("R10");
    snd(8'h81); snd(8'hC8);
    expi("R10");
    snd(8'h0F);
    expv("R10", 2'd3, 2'd0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 64'h33);
    snd(8'h04); snd(8'h33);
    // R11 lock cases
    expv("R11", 2'd1, 2'd2, 4'd0, 1'b0, 4'd3, 1'b0, 1'b1, 64'h0);
    snd(8'hF0); snd(8'h01); snd(8'h18);
    expi("R11");
    snd(8'hF0); snd(8'h01); snd(8'hD8);
    expi("R11");
    snd(8'hF0); snd(8'h04); snd(8'h01);
    expv("R11", 2'd3, 2'd0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 64'h02);
    snd(8'h04); snd(8'h02);
    // R4 extension prefix discarded by a later 0x66
    expv("R4", 2'd3, 2'd1, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 64'h1234);
    snd(8'h48); snd(8'h66); snd(8'h05); snd(8'h34); snd(8'h12);
    // R3 W wins over 0x66 when directly before the opcode
    expv("R3", 2'd2, 2'd3, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 64'h12345678);
    snd(8'h66); snd(8'h48); snd(8'h81); snd(8'hC0);
    snd(8'h78); snd(8'h56); snd(8'h34); snd(8'h12);
    // R5 two-byte immediate for 0x81 at 16 bits
    expv("R5", 2'd2, 2'd1, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 64'h8000);
    snd(8'h66); snd(8'h81); snd(8'hC0); snd(8'h00); snd(8'h80);
    in_valid = 1'b0;
    repeat (20) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1: pending records act=%0d exp=0", q.size());
    end
    finish_run();
  end
endmodule